// File: doc/BRIEF.md
# Matrix-Form Sum-of-Products Logic Array

This block evaluates a set of programmable sum-of-products functions by treating the AND plane of a logic array as a Boolean matrix product. The input variables form a row vector. A programmable node table holds one column per product term: a set bit in a column joins that input to the term. Each term is formed the De Morgan way. The inputs are complemented, ANDed with the column and ORed together, and the result is complemented again. That gives the AND of the selected inputs without a dedicated product-term gate.

An OR plane then combines the terms into the function outputs. Each term carries a routing mask that says which outputs it feeds, so unused or constant terms can be left out of any function. The table is written one term per cycle through a write-enable, term-index and data port. Evaluation is registered. The terms and functions for the input vector present at a rising edge appear on the outputs after that edge and hold until the next one.

Top module: `pla_matrix_sop`

## Requirements
- R1: Reset clears both output registers to zero and empties the table: every column and every routing mask becomes zero.
- R2: Input bit k (in_vec[k]) joins term t when bit k of that term's column is 1. term_out[t] is the AND of all joined inputs.
- R3: A term whose column is all zeros evaluates to 1 for every input vector.
- R4: func_out[o] is the OR of term_out[t] over every term t whose routing mask has bit o set. An output with no routed term is 0.
- R5: Both outputs are registered. They show the evaluation of the in_vec sampled at the most recent rising edge and do not follow in_vec between edges.
- R6: When cfg_we is high at a rising edge and cfg_term is below NUM_TERM, that term's column becomes cfg_col and its routing mask becomes cfg_route.
- R7: A write and an evaluation at the same edge do not interact. That evaluation uses the old table, and the new contents apply from the following edge.
- R8: A write with cfg_term at or above NUM_TERM changes no term.
- R9: With inputs A=in_vec[0], B=in_vec[1] and C=in_vec[2], columns 3'b101, 3'b110 and 3'b011 all routed to one output realize AC + BC + AB on that output.
- R10: While cfg_we is low, cfg_term, cfg_col and cfg_route have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_term | input | TW | Index of the term being written |
| cfg_col | input | NUM_IN | Node column for that term, bit k joins input k |
| cfg_route | input | NUM_OUT | Output routing mask for that term |
| in_vec | input | NUM_IN | Input variable vector |
| term_out | output | NUM_TERM | Registered product-term values |
| func_out | output | NUM_OUT | Registered function outputs |

## Verification
A table write and an evaluation can fall on the same rising edge. The bench provokes this by holding a fixed input vector while it rewrites a term with a column that flips that term's value. It then requires the first sample after the edge to match the old table and the next sample to match the new one. Around that case, full sweeps of all eight input vectors under many computed tables are compared against terms and functions derived arithmetically in the bench.

// File: rtl/pla_mx_pkg.sv
package pla_mx_pkg;

    // Widest input vector the term helper accepts
    localparam int MAX_IN = 32;

    // Complement-in, complement-out term: NOT(OR(NOT x AND col)) == AND of joined inputs
    function automatic logic demorgan_term(input logic [MAX_IN-1:0] x,
                                           input logic [MAX_IN-1:0] col);
        logic [MAX_IN-1:0] x_inv;
        logic              any_low;
        x_inv   = ~x;
        any_low = |(x_inv & col);
        return ~any_low;
    endfunction

    // Width of a term index for a given term count
    function automatic int idx_width(input int count);
        return (count > 1) ? $clog2(count) : 1;
    endfunction

endpackage

// File: rtl/pla_mx_store.sv
module pla_mx_store #(
    parameter int NUM_IN   = 3,
    parameter int NUM_TERM = 3,
    parameter int NUM_OUT  = 2,
    parameter int TW       = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               cfg_we,
    input  logic [TW-1:0]                      cfg_term,
    input  logic [NUM_IN-1:0]                  cfg_col,
    input  logic [NUM_OUT-1:0]                 cfg_route,
    output logic [NUM_TERM-1:0][NUM_IN-1:0]    col_tab,
    output logic [NUM_TERM-1:0][NUM_OUT-1:0]   route_tab
);

    for (genvar t = 0; t < NUM_TERM; t++) begin : g_slot
        logic hit;
        assign hit = cfg_we && (cfg_term == TW'(t));

        always_ff @(posedge clk) begin
            if (rst) begin
                col_tab[t]   <= '0;
                route_tab[t] <= '0;
            end else if (hit) begin
                col_tab[t]   <= cfg_col;
                route_tab[t] <= cfg_route;
            end
        end
    end

endmodule

// File: rtl/pla_mx_term.sv
module pla_mx_term
    import pla_mx_pkg::*;
#(
    parameter int NUM_IN = 3
) (
    input  logic [NUM_IN-1:0] x,
    input  logic [NUM_IN-1:0] col,
    output logic              prod
);

    logic [MAX_IN-1:0] x_w;
    logic [MAX_IN-1:0] col_w;

    // Unused upper column bits are zero, so they never pull the term low
    assign x_w   = MAX_IN'(x);
    assign col_w = MAX_IN'(col);
    assign prod  = demorgan_term(x_w, col_w);

endmodule

// File: rtl/pla_mx_orplane.sv
module pla_mx_orplane #(
    parameter int NUM_TERM = 3,
    parameter int NUM_OUT  = 2
) (
    input  logic [NUM_TERM-1:0]               terms,
    input  logic [NUM_TERM-1:0][NUM_OUT-1:0]  route,
    output logic [NUM_OUT-1:0]                func
);

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        logic [NUM_TERM-1:0] sel;
        for (genvar t = 0; t < NUM_TERM; t++) begin : g_sel
            assign sel[t] = terms[t] & route[t][o];
        end
        assign func[o] = |sel;
    end

endmodule

// File: rtl/pla_matrix_sop.sv
module pla_matrix_sop
    import pla_mx_pkg::*;
#(
    parameter int NUM_IN   = 3,
    parameter int NUM_TERM = 3,
    parameter int NUM_OUT  = 2,
    localparam int TW      = idx_width(NUM_TERM)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [TW-1:0]       cfg_term,
    input  logic [NUM_IN-1:0]   cfg_col,
    input  logic [NUM_OUT-1:0]  cfg_route,
    input  logic [NUM_IN-1:0]   in_vec,
    output logic [NUM_TERM-1:0] term_out,
    output logic [NUM_OUT-1:0]  func_out
);

    logic [NUM_TERM-1:0][NUM_IN-1:0]  col_tab;
    logic [NUM_TERM-1:0][NUM_OUT-1:0] route_tab;
    logic [NUM_TERM-1:0]              term_now;
    logic [NUM_OUT-1:0]               func_now;

    pla_mx_store #(
        .NUM_IN  (NUM_IN),
        .NUM_TERM(NUM_TERM),
        .NUM_OUT (NUM_OUT),
        .TW      (TW)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_term (cfg_term),
        .cfg_col  (cfg_col),
        .cfg_route(cfg_route),
        .col_tab  (col_tab),
        .route_tab(route_tab)
    );

    for (genvar t = 0; t < NUM_TERM; t++) begin : g_term
        pla_mx_term #(.NUM_IN(NUM_IN)) u_cell (
            .x   (in_vec),
            .col (col_tab[t]),
            .prod(term_now[t])
        );
    end

    pla_mx_orplane #(
        .NUM_TERM(NUM_TERM),
        .NUM_OUT (NUM_OUT)
    ) u_or (
        .terms(term_now),
        .route(route_tab),
        .func (func_now)
    );

    // Evaluation reads the table as it stands before this edge's write
    always_ff @(posedge clk) begin
        if (rst) begin
            term_out <= '0;
            func_out <= '0;
        end else begin
            term_out <= term_now;
            func_out <= func_now;
        end
    end

endmodule

// File: rtl/pla_mx_chk.sv
module pla_mx_chk #(
    parameter int NUM_IN   = 3,
    parameter int NUM_TERM = 3,
    parameter int NUM_OUT  = 2,
    parameter int TW       = 2
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              cfg_we,
    input logic [TW-1:0]                     cfg_term,
    input logic [NUM_IN-1:0]                 cfg_col,
    input logic [NUM_IN-1:0]                 in_vec,
    input logic [NUM_TERM-1:0]               term_out,
    input logic [NUM_OUT-1:0]                func_out,
    input logic [NUM_TERM-1:0][NUM_IN-1:0]   col_tab,
    input logic [NUM_TERM-1:0][NUM_OUT-1:0]  route_tab
);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R2
    all_ones_in_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(in_vec) == '1) |-> term_out == '1);

    // R4
    func_needs_term_chk: assert property (@(posedge clk) disable iff (rst)
        (|func_out) |-> (|term_out));

    // R10
    idle_table_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(cfg_we)) |-> ($stable(col_tab) && $stable(route_tab)));

    // R8
    range_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(cfg_we) && $past(cfg_term) >= TW'(NUM_TERM - 1) + TW'(1)
         && TW'(NUM_TERM - 1) != '1)
        |-> ($stable(col_tab) && $stable(route_tab)));

    // R6
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(cfg_we) && $past(cfg_term) <= TW'(NUM_TERM - 1))
        |-> col_tab[$past(cfg_term)] == $past(cfg_col));

endmodule

bind pla_matrix_sop pla_mx_chk #(
    .NUM_IN  (NUM_IN),
    .NUM_TERM(NUM_TERM),
    .NUM_OUT (NUM_OUT),
    .TW      (TW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_we   (cfg_we),
    .cfg_term (cfg_term),
    .cfg_col  (cfg_col),
    .in_vec   (in_vec),
    .term_out (term_out),
    .func_out (func_out),
    .col_tab  (col_tab),
    .route_tab(route_tab)
);

// File: tb/pla_matrix_sop_test.sv
module pla_matrix_sop_test;

    localparam int NI = 3;
    localparam int NT = 3;
    localparam int NO = 2;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we;
    logic [TW-1:0] cfg_term;
    logic [NI-1:0] cfg_col;
    logic [NO-1:0] cfg_route;
    logic [NI-1:0] in_vec;
    logic [NT-1:0] term_out;
    logic [NO-1:0] func_out;

    int n_chk  = 0;
    int n_fail = 0;

    logic [NI-1:0] m_col   [NT];
    logic [NO-1:0] m_route [NT];

    always #5 clk = ~clk;

    pla_matrix_sop #(.NUM_IN(NI), .NUM_TERM(NT), .NUM_OUT(NO)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_term(cfg_term),
        .cfg_col(cfg_col), .cfg_route(cfg_route), .in_vec(in_vec),
        .term_out(term_out), .func_out(func_out)
    );

    function automatic logic [NT-1:0] exp_terms(input logic [NI-1:0] x);
        logic [NT-1:0] r;
        for (int t = 0; t < NT; t++) r[t] = ((x & m_col[t]) == m_col[t]);
        return r;
    endfunction

    function automatic logic [NO-1:0] exp_func(input logic [NI-1:0] x);
        logic [NT-1:0] tv;
        logic [NO-1:0] r;
        tv = exp_terms(x);
        r  = '0;
        for (int o = 0; o < NO; o++)
            for (int t = 0; t < NT; t++)
                if (m_route[t][o] && tv[t]) r[o] = 1'b1;
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic write_term(input int t, input logic [NI-1:0] col, input logic [NO-1:0] rt);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_term  = TW'(t);
        cfg_col   = col;
        cfg_route = rt;
        @(negedge clk);
        cfg_we = 1'b0;
        if (t < NT) begin
            m_col[t]   = col;
            m_route[t] = rt;
        end
    endtask

    // Drive at negedge, result sampled one edge later at the next negedge
    task automatic evaluate(input logic [NI-1:0] x, input string tag);
        logic [NT-1:0] pt;
        logic [NO-1:0] pf;
        @(negedge clk);
        pt = term_out;
        pf = func_out;
        in_vec = x;
        #1;
        check("R5 hold between edges", {pt, pf}, {term_out, func_out});
        @(negedge clk);
        check({tag, " terms"}, 32'(term_out), 32'(exp_terms(x)));
        check({tag, " func"},  32'(func_out), 32'(exp_func(x)));
    endtask

    task automatic sweep(input string tag);
        for (int x = 0; x < 8; x++) evaluate(NI'(x), tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_term = '0; cfg_col = '0; cfg_route = '0; in_vec = '0;
        for (int t = 0; t < NT; t++) begin m_col[t] = '0; m_route[t] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs cleared right after reset
        check("R1 reset terms", 32'(term_out), 32'h0);
        check("R1 reset func",  32'(func_out), 32'h0);
        // R1 / R3: empty table gives constant-1 terms, no routed function
        sweep("R1 R3 empty table");

        // R10: scribble on the write port with we low
        @(negedge clk);
        cfg_term = 2'd1; cfg_col = 3'b111; cfg_route = 2'b11;
        repeat (2) @(negedge clk);
        sweep("R10 no write");

        // R9: majority function on output 0, A&C alone on output 1
        write_term(0, 3'b101, 2'b11);
        write_term(1, 3'b110, 2'b01);
        write_term(2, 3'b011, 2'b01);
        for (int x = 0; x < 8; x++) begin
            logic [NI-1:0] xv;
            xv = NI'(x);
            evaluate(xv, "R9 R2 R6 majority");
            check("R9 majority value", 32'(func_out[0]),
                  32'((32'(xv[0]) + 32'(xv[1]) + 32'(xv[2])) >= 2));
            check("R4 single term output", 32'(func_out[1]), 32'(xv[0] & xv[2]));
        end

        // R8: out-of-range index leaves the table alone
        write_term(3, 3'b000, 2'b11);
        sweep("R8 out of range");

        // R7: write and evaluation at one edge, input held at A=1,B=0,C=0
        evaluate(3'b001, "R7 setup");
        @(negedge clk);
        cfg_we = 1'b1; cfg_term = 2'd1; cfg_col = 3'b001; cfg_route = 2'b01;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R7 same edge uses old table", 32'({term_out, func_out}), 32'({3'b000, 2'b00}));
        m_col[1] = 3'b001; m_route[1] = 2'b01;
        @(negedge clk);
        check("R7 next edge uses new table", 32'({term_out, func_out}), 32'({3'b010, 2'b01}));

        // R3: zero column forces its term; routing can mask it out
        write_term(1, 3'b000, 2'b01);
        sweep("R3 zero column routed");
        write_term(1, 3'b000, 2'b00);
        sweep("R3 R4 zero column masked");

        // R2 R4 R6: many computed tables, all inputs
        for (int c = 0; c < 48; c++) begin
            for (int t = 0; t < NT; t++)
                write_term(t, NI'((c * 5 + t * 3 + c / 8) % 8), NO'((c + t * 3) % 4));
            sweep("R2 R4 R6 table sweep");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule